// File: doc/BRIEF.md
# Masked Status Read-Back Sequencer

This block is the read half of a DMA controller's register port. Software loads a seven-bit selection mask. The mask picks which internal bytes come back on later reads: the status byte, the two bytes of the transfer counter, and the two bytes of each port's address counter. Each read strobe returns the next selected byte. After the last selected byte, the sequence starts again at the first.

If the mask selects nothing, every read returns a status byte built from the live channel state. A dedicated status command replaces the mask with one that selects only the status byte, and it re-arms the sequence in the same step. The write side of the register port and the transfer engine sit outside this block. They supply the live counter and flag values as inputs.

Top module: `masked_readback_seq`

## Requirements
- R1: During and right after a synchronous reset, the read data output is 0x38 and the read list is empty.
- R2: Mask bit k selects slot k. The slots, in read order, are: 0 status, 1 counter low byte, 2 counter high byte, 3 port A address low byte, 4 port A address high byte, 5 port B address low byte, 6 port B address high byte. A high byte is the top 8 bits of its word.
- R3: An arm strobe captures the mask, builds the list of selected slots in ascending order, and points the sequence at the first entry. This includes an arm in the middle of a sequence.
- R4: A read of the last selected entry is followed by a read of the first entry.
- R5: The status byte is 0xCC, with three bits ORed in: bit 0 when the channel is enabled, bit 4 when no match has occurred, and bit 5 when the end of block has not been reached.
- R6: Status bit 1 is set when the mode input is not 1 and the ready input differs from the programmed active level. Otherwise it is clear.
- R7: With an empty list (mask 0), every read returns the status byte built from the inputs present in that cycle.
- R8: A status command sets the list to the single status slot and rewinds the sequence. It takes priority over an arm in the same cycle.
- R9: Read data is registered at the clock edge on which the read strobe is high. Each strobe advances the sequence by exactly one entry. Without a strobe, the output holds its value.
- R10: When an arm or status command arrives in the same cycle as a read strobe, the read is dropped: the output holds, and the new list starts from its first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Capture mask_i and rewind the sequence |
| mask_i | input | 7 | Slot selection mask |
| status_cmd_i | input | 1 | Force a status-only list and rewind |
| rd_i | input | 1 | Read strobe |
| chan_en_i | input | 1 | Channel enabled flag |
| match_hit_i | input | 1 | A match has occurred |
| block_done_i | input | 1 | End of block reached |
| mode_i | input | 2 | Transfer mode |
| ready_i | input | 1 | Ready input level |
| ready_lvl_i | input | 1 | Programmed ready active level |
| byte_cnt_i | input | WORD_W | Live transfer counter |
| addr_a_i | input | WORD_W | Live port A address counter |
| addr_b_i | input | WORD_W | Live port B address counter |
| rd_data_o | output | 8 | Registered read data |

## Verification
The bench builds the block with the default WORD_W of 16. With that width, every slot's byte is a distinct, recognisable value, so any misordered or misselected slot produces a different output byte. A mask table covers full, single-bit, sparse and empty selections, and follows each over enough reads to wrap. Directed tests cover the status bit rules, re-arming mid-sequence, the status command, and a read that collides with an arm.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 7;
    localparam int IDX_W     = 3;

    typedef logic [IDX_W-1:0] slot_t;

    localparam slot_t SL_STATUS = 3'd0;
    localparam slot_t SL_CNT_LO = 3'd1;
    localparam slot_t SL_CNT_HI = 3'd2;
    localparam slot_t SL_A_LO   = 3'd3;
    localparam slot_t SL_A_HI   = 3'd4;
    localparam slot_t SL_B_LO   = 3'd5;
    localparam slot_t SL_B_HI   = 3'd6;

    localparam logic [BYTE_W-1:0] STATUS_BASE  = 8'hCC;
    localparam logic [BYTE_W-1:0] RESET_DATA   = 8'h38;
    localparam logic [NUM_SLOTS-1:0] ONLY_STAT = 7'h01;

    typedef struct packed {
        logic       enabled;
        logic       match_hit;
        logic       block_done;
        logic [1:0] mode;
        logic       ready;
        logic       ready_lvl;
    } chan_state_t;

    function automatic logic [BYTE_W-1:0] build_status(chan_state_t s);
        logic [BYTE_W-1:0] b;
        b    = STATUS_BASE;
        b[0] = s.enabled;
        b[1] = (s.mode != 2'd1) && (s.ready != s.ready_lvl);
        b[4] = ~s.match_hit;
        b[5] = ~s.block_done;
        return b;
    endfunction
endpackage

// File: rtl/rbk_status_compose.sv
module rbk_status_compose
    import rbk_pkg::*;
(
    input  chan_state_t       state_i,
    output logic [BYTE_W-1:0] status_o
);
    always_comb status_o = build_status(state_i);
endmodule

// File: rtl/rbk_order_list.sv
module rbk_order_list
    import rbk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic [NUM_SLOTS-1:0] mask_i,
    output slot_t [NUM_SLOTS-1:0] list_o,
    output logic [IDX_W-1:0]     count_o
);
    slot_t [NUM_SLOTS-1:0] list_d;
    logic [IDX_W-1:0]      count_d;

    always_comb begin
        list_d  = '0;
        count_d = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (mask_i[i]) begin
                list_d[count_d] = slot_t'(i);
                count_d         = count_d + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            list_o  <= '0;
            count_o <= '0;
        end else if (load_i) begin
            list_o  <= list_d;
            count_o <= count_d;
        end
    end
endmodule

// File: rtl/rbk_slot_mux.sv
module rbk_slot_mux
    import rbk_pkg::*;
#(
    parameter int WORD_W = 16
)(
    input  slot_t             sel_i,
    input  logic [BYTE_W-1:0] status_i,
    input  logic [WORD_W-1:0] cnt_i,
    input  logic [WORD_W-1:0] addr_a_i,
    input  logic [WORD_W-1:0] addr_b_i,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int HI_MSB = WORD_W - 1;

    logic [BYTE_W-1:0] cand [NUM_SLOTS];

    always_comb begin
        cand[SL_STATUS] = status_i;
        cand[SL_CNT_LO] = cnt_i[BYTE_W-1:0];
        cand[SL_CNT_HI] = cnt_i[HI_MSB -: BYTE_W];
        cand[SL_A_LO]   = addr_a_i[BYTE_W-1:0];
        cand[SL_A_HI]   = addr_a_i[HI_MSB -: BYTE_W];
        cand[SL_B_LO]   = addr_b_i[BYTE_W-1:0];
        cand[SL_B_HI]   = addr_b_i[HI_MSB -: BYTE_W];
        byte_o = (int'(sel_i) < NUM_SLOTS) ? cand[sel_i] : status_i;
    end
endmodule

// File: rtl/masked_readback_seq.sv
module masked_readback_seq
    import rbk_pkg::*;
#(
    parameter int WORD_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic [6:0]        mask_i,
    input  logic              status_cmd_i,
    input  logic              rd_i,
    input  logic              chan_en_i,
    input  logic              match_hit_i,
    input  logic              block_done_i,
    input  logic [1:0]        mode_i,
    input  logic              ready_i,
    input  logic              ready_lvl_i,
    input  logic [WORD_W-1:0] byte_cnt_i,
    input  logic [WORD_W-1:0] addr_a_i,
    input  logic [WORD_W-1:0] addr_b_i,
    output logic [7:0]        rd_data_o
);
    chan_state_t           chan;
    logic [BYTE_W-1:0]     status_byte;
    logic                  load;
    logic [NUM_SLOTS-1:0]  load_mask;
    slot_t [NUM_SLOTS-1:0] list;
    logic [IDX_W-1:0]      count;
    logic [IDX_W-1:0]      ptr;
    logic [IDX_W-1:0]      ptr_inc;
    logic [BYTE_W-1:0]     slot_byte;
    logic [BYTE_W-1:0]     next_data;

    always_comb begin
        chan.enabled    = chan_en_i;
        chan.match_hit  = match_hit_i;
        chan.block_done = block_done_i;
        chan.mode       = mode_i;
        chan.ready      = ready_i;
        chan.ready_lvl  = ready_lvl_i;
    end

    assign load      = arm_i | status_cmd_i;
    assign load_mask = status_cmd_i ? ONLY_STAT : mask_i;

    rbk_status_compose u_status (
        .state_i  (chan),
        .status_o (status_byte)
    );

    rbk_order_list u_list (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .mask_i  (load_mask),
        .list_o  (list),
        .count_o (count)
    );

    rbk_slot_mux #(.WORD_W(WORD_W)) u_mux (
        .sel_i    (list[ptr]),
        .status_i (status_byte),
        .cnt_i    (byte_cnt_i),
        .addr_a_i (addr_a_i),
        .addr_b_i (addr_b_i),
        .byte_o   (slot_byte)
    );

    assign ptr_inc   = ptr + 1'b1;
    assign next_data = (count == '0) ? status_byte : slot_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= '0;
            rd_data_o <= RESET_DATA;
        end else if (load) begin
            ptr <= '0;
        end else if (rd_i) begin
            rd_data_o <= next_data;
            if (count != '0)
                ptr <= (ptr_inc >= count) ? '0 : ptr_inc;
        end
    end
endmodule

// File: rtl/masked_readback_seq_chk.sv
module masked_readback_seq_chk
    import rbk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              arm_i,
    input logic              status_cmd_i,
    input logic              rd_i,
    input logic [IDX_W-1:0]  ptr,
    input logic [IDX_W-1:0]  count,
    input logic [BYTE_W-1:0] status_byte,
    input logic [7:0]        rd_data_o
);
    logic ld;
    assign ld = arm_i | status_cmd_i;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (rd_data_o == 8'h38 && count == '0));

    assert_ptr_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        (count != '0) |-> (ptr < count));

    assert_arm_rewinds_R3: assert property (@(posedge clk) disable iff (rst)
        ld |=> (ptr == '0));

    assert_status_cmd_single_R8: assert property (@(posedge clk) disable iff (rst)
        status_cmd_i |=> (count == 3'd1));

    assert_hold_no_read_R9: assert property (@(posedge clk) disable iff (rst)
        (!rd_i || ld) |=> $stable(rd_data_o));

    assert_empty_gives_status_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !ld && count == '0) |=> (rd_data_o == $past(status_byte)));
endmodule

bind masked_readback_seq masked_readback_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .arm_i        (arm_i),
    .status_cmd_i (status_cmd_i),
    .rd_i         (rd_i),
    .ptr          (ptr),
    .count        (count),
    .status_byte  (status_byte),
    .rd_data_o    (rd_data_o)
);

// File: tb/test_masked_readback_seq.sv
module test_masked_readback_seq;
    logic        clk = 0;
    logic        rst = 1;
    logic        arm_i = 0;
    logic [6:0]  mask_i = '0;
    logic        status_cmd_i = 0;
    logic        rd_i = 0;
    logic        chan_en_i = 1;
    logic        match_hit_i = 0;
    logic        block_done_i = 0;
    logic [1:0]  mode_i = 2'd1;
    logic        ready_i = 0;
    logic        ready_lvl_i = 0;
    logic [15:0] byte_cnt_i = 16'h1234;
    logic [15:0] addr_a_i = 16'h5678;
    logic [15:0] addr_b_i = 16'h9ABC;
    logic [7:0]  rd_data_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    masked_readback_seq i_masked_readback_seq (.*);

    // mask, then four expected bytes in read order (live status 0xFD)
    localparam logic [38:0] VEC [8] = '{
        {7'h7F, 32'hFD341278},
        {7'h01, 32'hFDFDFDFD},
        {7'h00, 32'hFDFDFDFD},
        {7'h06, 32'h34123412},
        {7'h50, 32'h569A569A},
        {7'h28, 32'h78BC78BC},
        {7'h40, 32'h9A9A9A9A},
        {7'h15, 32'hFD1256FD}
    };

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic do_arm(logic [6:0] m);
        @(negedge clk); mask_i = m; arm_i = 1;
        @(negedge clk); arm_i = 0;
    endtask

    task automatic do_read;
        @(negedge clk); rd_i = 1;
        @(negedge clk); rd_i = 0;
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset data", rd_data_o, 8'h38);
        rst = 0;
        @(negedge clk);
        check("R1 after reset", rd_data_o, 8'h38);
        do_read;
        check("R1 empty list after reset", rd_data_o, 8'hFD);

        // table walk: R2 R3 R4 R7
        for (int v = 0; v < 8; v++) begin
            do_arm(VEC[v][38:32]);
            for (int r = 0; r < 4; r++) begin
                do_read;
                check($sformatf("R2/R4 mask %02h read %0d", VEC[v][38:32], r),
                      rd_data_o, VEC[v][31-8*r -: 8]);
            end
        end

        // R4: full wrap after 7 entries
        do_arm(7'h7F);
        repeat (7) do_read;
        check("R4 seventh entry", rd_data_o, 8'h9A);
        do_read;
        check("R4 wrap to first", rd_data_o, 8'hFD);

        // R3: re-arm mid sequence
        do_arm(7'h7F);
        do_read; do_read;
        do_arm(7'h7F);
        do_read;
        check("R3 rearm rewinds", rd_data_o, 8'hFD);

        // R5 / R6 / R7: status composition, live
        do_arm(7'h00);
        chan_en_i = 0; match_hit_i = 1; block_done_i = 1;
        do_read;
        check("R5 all clear", rd_data_o, 8'hCC);
        chan_en_i = 1; match_hit_i = 0; block_done_i = 0;
        mode_i = 2'd2; ready_i = 0; ready_lvl_i = 1;
        do_read;
        check("R6 mode2 not ready", rd_data_o, 8'hFF);
        mode_i = 2'd1;
        do_read;
        check("R6 mode1 masks ready", rd_data_o, 8'hFD);
        mode_i = 2'd0; ready_i = 1;
        do_read;
        check("R6 ready at level", rd_data_o, 8'hFD);
        mode_i = 2'd1; ready_i = 0; ready_lvl_i = 0;
        byte_cnt_i = 16'hAA55;
        do_read;
        check("R7 empty list ignores counter", rd_data_o, 8'hFD);
        byte_cnt_i = 16'h1234;

        // R8: status command overrides mask
        do_arm(7'h06);
        do_read;
        check("R8 before cmd", rd_data_o, 8'h34);
        @(negedge clk); status_cmd_i = 1; arm_i = 1; mask_i = 7'h06;
        @(negedge clk); status_cmd_i = 0; arm_i = 0;
        do_read;
        check("R8 status only", rd_data_o, 8'hFD);
        do_read;
        check("R8 status only repeat", rd_data_o, 8'hFD);

        // R9: hold without strobe, one step per strobe
        do_arm(7'h06);
        do_read;
        repeat (5) @(negedge clk);
        check("R9 hold", rd_data_o, 8'h34);
        do_read;
        check("R9 single step", rd_data_o, 8'h12);

        // R10: arm and read together
        @(negedge clk); mask_i = 7'h28; arm_i = 1; rd_i = 1;
        @(negedge clk); arm_i = 0; rd_i = 0;
        check("R10 read dropped", rd_data_o, 8'h12);
        do_read;
        check("R10 new list first", rd_data_o, 8'h78);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule